// File: doc/BRIEF.md
# SPI EEPROM Page Write Controller

This block is a host-side SPI master that carries out one complete page write to a serial EEPROM and then reports the outcome. A client first fills a 16-entry byte buffer through a simple write port. It then pulses a start request with a 9-bit start address and a byte count. The controller checks the request. If the request is valid, it sends a write-enable frame, sends the write frame, and polls the device status until the internal programming cycle has finished.

The serial bus runs in mode 0: the clock idles low, data out changes only while the clock is low, and data in is sampled on each rising clock edge. Every byte is sent most significant bit first. The ninth address bit travels inside the write instruction byte. The low eight address bits follow the instruction byte, and the data bytes follow the address. Chip select goes high between frames for a programmable minimum time.

A request that the device could not take as one page write is refused before any bus activity. A write that never finishes is abandoned after a parameterised number of status reads.

Top module: `spi_pgwr_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and busy, done and error are all low.
- R2: The serial clock is low whenever no byte is in flight. Data out changes only while the clock is low. Each byte goes out most significant bit first, and each byte occupies 8 clock pulses of 2*CLK_DIV system cycles.
- R3: Every accepted request begins with a frame that holds only the byte 0x06 (write enable), in its own chip-select window.
- R4: The second frame holds, in order: the byte 0x02 with address bit 8 placed at bit 3; then address bits 7..0; then `count_i` bytes taken from buffer entries 0, 1, 2 and so on.
- R5: Chip select rises only after a whole number of bytes, with the serial clock low, and within 2 system cycles of the last falling clock edge.
- R6: Between any two chip-select-low windows, chip select stays high for at least CS_GAP system cycles. This includes the gap between consecutive requests.
- R7: After the write frame, the block sends status frames, each made of 0x05 followed by one read byte. It repeats them while bit 0 of the read byte is 1. When bit 0 reads 0, it raises `done_o` for one cycle.
- R8: A request is rejected when the count is 0, the count exceeds 16, or (address bits 3..0) plus the count exceeds 16. Rejection gives a one-cycle `err_o` in the cycle after the start, with no chip-select activity and busy staying low.
- R9: If POLL_LIMIT consecutive status reads all show bit 0 set, the block raises `err_o` for one cycle instead of `done_o`.
- R10: `busy_o` goes high in the cycle after an accepted start and falls in the cycle where done or error is raised. A start request made while busy is ignored. A start request made in the cycle where done is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| addr_i | input | 9 | Start byte address in the EEPROM |
| count_i | input | 5 | Number of bytes to write |
| buf_we_i | input | 1 | Buffer write enable |
| buf_idx_i | input | 4 | Buffer entry to write |
| buf_data_i | input | 8 | Buffer write data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse when the write has completed |
| err_o | output | 1 | One-cycle pulse on rejection or poll timeout |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the device |
| spi_miso_i | input | 1 | Serial data from the device |

## Verification
The two functions that can coincide are the completion pulse of one request and the start of the next. The bench raises `start_i` in the exact cycle where `done_o` is seen high. It then expects busy to rise one cycle later and a fresh, correctly spaced write-enable frame to follow. Separately, a start request is injected while a write is already in flight. That case is judged by the frame log: the log must show exactly the original request's frames and a single completion.

// File: rtl/spi_pgwr_pkg.sv
package spi_pgwr_pkg;
  localparam int unsigned ADDR_W  = 9;
  localparam logic [7:0]  OP_WEN  = 8'h06;
  localparam logic [7:0]  OP_WR   = 8'h02;
  localparam logic [7:0]  OP_STAT = 8'h05;
  localparam int unsigned HI_ADDR_POS = 3;  // where address bit 8 sits in the opcode
  localparam int unsigned BUSY_BIT    = 0;  // write-in-progress flag in status

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_XFER, ST_GAP} ctl_state_e;
  typedef enum logic [1:0] {FR_WEN, FR_WR, FR_STAT} frame_e;
endpackage

// File: rtl/spi_pgwr_buf.sv
module spi_pgwr_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/spi_pgwr_chk.sv
module spi_pgwr_chk #(
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_W     = 9,
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1),
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              ok_o
);
  logic [CNT_W:0] end_pos;

  assign end_pos = (CNT_W+1)'(addr_i[OFF_W-1:0]) + (CNT_W+1)'(count_i);
  assign ok_o = (count_i != '0) &&
                ((CNT_W+1)'(count_i) <= (CNT_W+1)'(PAGE_BYTES)) &&
                (end_pos <= (CNT_W+1)'(PAGE_BYTES));
endmodule

// File: rtl/spi_pgwr_shift.sv
module spi_pgwr_shift #(
  parameter int CLK_DIV = 4,
  localparam int DC_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  logic            active_q, sck_q, done_q;
  logic [DC_W-1:0] div_q;
  logic [2:0]      bit_q;
  logic [7:0]      sr_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
      div_q <= '0; bit_q <= '0; sr_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        sr_q     <= tx_i;
        div_q    <= '0;
        bit_q    <= '0;
        sck_q    <= 1'b0;
      end else if (active_q) begin
        if (div_q == DC_W'(CLK_DIV - 1)) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sr_q  <= {sr_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DC_W'(1);
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sr_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  AST_MOSI_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(mosi_o)); // R2
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sck_q); // R2
endmodule

// File: rtl/spi_pgwr_ctrl.sv
module spi_pgwr_ctrl
  import spi_pgwr_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int CLK_DIV    = 4,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 1024,
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1),
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              buf_we_i,
  input  logic [IDX_W-1:0]  buf_idx_i,
  input  logic [7:0]        buf_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              spi_cs_no,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int BI_W  = CNT_W + 1;
  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam int PC_W  = $clog2(POLL_LIMIT + 1);

  ctl_state_e        state_q;
  frame_e            frame_q;
  logic              cs_n_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BI_W-1:0]   byte_q, last_idx;
  logic [GAP_W-1:0]  gap_q;
  logic [PC_W-1:0]   poll_q;
  logic              req_ok, sh_done, sh_go;
  logic [7:0]        sh_rx, tx_byte, buf_rd;
  logic [IDX_W-1:0]  buf_ridx;

  spi_pgwr_chk #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_chk (
    .addr_i(addr_i), .count_i(count_i), .ok_o(req_ok));

  spi_pgwr_buf #(.DEPTH(PAGE_BYTES), .DW(8)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(buf_we_i), .widx_i(buf_idx_i),
    .wdata_i(buf_data_i), .ridx_i(buf_ridx), .rdata_o(buf_rd));

  assign sh_go = (state_q == ST_LOAD);

  spi_pgwr_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(sh_go), .tx_i(tx_byte),
    .miso_i(spi_miso_i), .sck_o(spi_sck_o), .mosi_o(spi_mosi_o),
    .done_o(sh_done), .rx_o(sh_rx));

  // data bytes follow opcode and address
  assign buf_ridx = IDX_W'(byte_q - BI_W'(2));

  always_comb begin
    tx_byte  = 8'h00;
    last_idx = '0;
    unique case (frame_q)
      FR_WEN: tx_byte = OP_WEN;
      FR_WR: begin
        last_idx = BI_W'(cnt_q) + BI_W'(1);
        if (byte_q == '0)
          tx_byte = OP_WR | (8'(addr_q[ADDR_W-1]) << HI_ADDR_POS);
        else if (byte_q == BI_W'(1))
          tx_byte = addr_q[7:0];
        else
          tx_byte = buf_rd;
      end
      FR_STAT: begin
        last_idx = BI_W'(1);
        tx_byte  = (byte_q == '0) ? OP_STAT : 8'h00;
      end
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; frame_q <= FR_WEN; cs_n_q <= 1'b1;
      done_q <= 1'b0; err_q <= 1'b0; addr_q <= '0; cnt_q <= '0;
      byte_q <= '0; gap_q <= '0; poll_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (req_ok) begin
            addr_q  <= addr_i;
            cnt_q   <= count_i;
            frame_q <= FR_WEN;
            byte_q  <= '0;
            poll_q  <= '0;
            gap_q   <= '0;
            state_q <= ST_GAP;   // guard gap also separates requests
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_LOAD: state_q <= ST_XFER;
        ST_XFER: if (sh_done) begin
          if (byte_q == last_idx) begin
            cs_n_q <= 1'b1;
            byte_q <= '0;
            unique case (frame_q)
              FR_WEN: begin frame_q <= FR_WR;   state_q <= ST_GAP; end
              FR_WR:  begin frame_q <= FR_STAT; state_q <= ST_GAP; end
              default: begin
                if (!sh_rx[BUSY_BIT]) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
                end else if (poll_q == PC_W'(POLL_LIMIT - 1)) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  poll_q  <= poll_q + PC_W'(1);
                  state_q <= ST_GAP;
                end
              end
            endcase
          end else begin
            byte_q  <= byte_q + BI_W'(1);
            state_q <= ST_LOAD;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(CS_GAP - 1)) begin
            gap_q   <= '0;
            cs_n_q  <= 1'b0;
            state_q <= ST_LOAD;
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign spi_cs_no = cs_n_q;

  AST_CS_HIGH_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o); // R5
  AST_BUSY_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R10
  AST_REJECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && $past(state_q == ST_IDLE)) |-> (spi_cs_no && !busy_o)); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R7
  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PC_W'(POLL_LIMIT)); // R9
endmodule

// File: tb/spi_pgwr_ctrl_tb_top.sv
module spi_pgwr_ctrl_tb_top;
  localparam int PAGE = 16;
  localparam int DIV  = 2;
  localparam int GAP  = 3;
  localparam int PL   = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, buf_we_i = 1'b0;
  logic [8:0] addr_i = '0;
  logic [4:0] count_i = '0;
  logic [3:0] buf_idx_i = '0;
  logic [7:0] buf_data_i = '0;
  logic busy_o, done_o, err_o, cs_n, sck, mosi;
  logic miso = 1'b0;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  spi_pgwr_ctrl #(.PAGE_BYTES(PAGE), .CLK_DIV(DIV), .CS_GAP(GAP), .POLL_LIMIT(PL)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i), .count_i(count_i),
    .buf_we_i(buf_we_i), .buf_idx_i(buf_idx_i), .buf_data_i(buf_data_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso));

  // ---------------- device model / frame log ----------------
  bit        mon_en = 0;
  int        nf, k, wip_left, gap_bad, sck_bad, part_bad, hi_cnt;
  int        flen [64];
  logic [7:0] fb [64][18];
  logic [7:0] sh, stat;
  bit        rd;
  logic [7:0] exp_buf [16];

  always @(posedge clk_i) if (cs_n === 1'b1) hi_cnt++; else hi_cnt = 0;

  always @(negedge cs_n) if (mon_en) begin
    if (hi_cnt < GAP) gap_bad++;
    k = 0; rd = 0;
  end

  always @(posedge sck) if (mon_en && cs_n === 1'b0) begin
    sh = {sh[6:0], mosi};
    k++;
    if (k % 8 == 0 && nf < 64 && k / 8 <= 18) fb[nf][k/8-1] = sh;
    if (k == 8 && sh == 8'h05) begin
      rd = 1;
      stat = (wip_left > 0) ? 8'hF1 : 8'hF0;
    end
  end

  always @(negedge sck) if (mon_en && cs_n === 1'b0 && rd && k >= 8 && k < 16)
    miso = stat[15-k];

  always @(posedge cs_n) if (mon_en) begin
    if (sck !== 1'b0) sck_bad++;
    if (k % 8 != 0) part_bad++;
    if (rd && wip_left > 0) wip_left--;
    if (nf < 64) flen[nf] = k / 8;
    nf++;
    rd = 0;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic load_buf(input int seed);
    for (int i = 0; i < 16; i++) begin
      exp_buf[i]  = 8'((i * 37 + seed * 11 + 5) & 255);
      buf_we_i    = 1'b1;
      buf_idx_i   = 4'(i);
      buf_data_i  = exp_buf[i];
      @(posedge clk_i); @(negedge clk_i);
    end
    buf_we_i = 1'b0;
  endtask

  task automatic pulse_start(input logic [8:0] a, input logic [4:0] c, input int wip);
    wip_left = wip; nf = 0; gap_bad = 0; sck_bad = 0; part_bad = 0;
    addr_i = a; count_i = c; start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic expect_reject(input logic [8:0] a, input logic [4:0] c);
    pulse_start(a, c, 0);
    chk(err_o == 1'b1, "R8 reject err pulse", int'(err_o), 1);
    chk(busy_o == 1'b0, "R8 reject busy low", int'(busy_o), 0);
    repeat (GAP + 4) @(negedge clk_i);
    chk(nf == 0 && cs_n == 1'b1, "R8 reject no bus activity", nf, 0);
  endtask

  task automatic expect_run(input logic [8:0] a, input logic [4:0] c, input int wip, input bit poke);
    int n, polls, mism, pbad;
    bit exp_done;
    logic [7:0] exp_op;
    chk(busy_o == 1'b1, "R10 busy after accepted start", int'(busy_o), 1);
    if (poke) begin
      start_i = 1'b1; addr_i = a ^ 9'h10; count_i = 5'd1;
      @(posedge clk_i); @(negedge clk_i);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && !err_o && n < 20000) begin @(negedge clk_i); n++; end
    exp_done = (wip < PL);
    polls    = exp_done ? wip + 1 : PL;
    exp_op   = 8'h02 | (8'(a[8]) << 3);
    chk(done_o == exp_done, exp_done ? "R7 done pulse" : "R9 no done on timeout", int'(done_o), int'(exp_done));
    chk(err_o == !exp_done, exp_done ? "R7 no error" : "R9 timeout error", int'(err_o), int'(!exp_done));
    chk(busy_o == 1'b0, "R10 busy falls with outcome", int'(busy_o), 0);
    chk(nf == 2 + polls, "R7 frame count", nf, 2 + polls);
    chk(flen[0] == 1 && fb[0][0] == 8'h06, "R3 enable frame", int'(fb[0][0]), 6);
    chk(flen[1] == int'(c) + 2, "R4 write frame length", flen[1], int'(c) + 2);
    chk(fb[1][0] == exp_op, "R4 opcode with A8", int'(fb[1][0]), int'(exp_op));
    chk(fb[1][1] == a[7:0], "R4 low address", int'(fb[1][1]), int'(a[7:0]));
    mism = 0;
    for (int i = 0; i < int'(c); i++) if (fb[1][i+2] != exp_buf[i]) mism++;
    chk(mism == 0, "R4 R2 data bytes msb first", mism, 0);
    pbad = 0;
    for (int p = 2; p < nf && p < 64; p++) if (flen[p] != 2 || fb[p][0] != 8'h05) pbad++;
    chk(pbad == 0, "R7 status frames", pbad, 0);
    chk(part_bad == 0 && sck_bad == 0, "R5 whole bytes, clock low at release", part_bad + sck_bad, 0);
    chk(gap_bad == 0, "R6 chip select gap", gap_bad, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk_i);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 reset bus idle", int'({cs_n, sck}), 2);
    chk(!busy_o && !done_o && !err_o, "R1 reset status low", int'({busy_o, done_o, err_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    mon_en = 1;
    load_buf(1);

    // sweep every offset and count, valid and invalid
    for (int off = 0; off < 16; off++) begin
      for (int c = 0; c <= 17; c++) begin
        logic [8:0] a;
        a = {1'(c & 1), 4'((off * 5 + c) & 15), 4'(off)};
        if (c >= 1 && off + c <= 16) begin
          pulse_start(a, 5'(c), (off + c) % 3);
          expect_run(a, 5'(c), (off + c) % 3, 1'b0);
        end else begin
          expect_reject(a, 5'(c));
        end
      end
      load_buf(off + 2);
    end

    // R9: busy bit never clears
    pulse_start(9'h1A3, 5'd4, 100);
    expect_run(9'h1A3, 5'd4, 100, 1'b0);
    load_buf(40);

    // R10: start while busy is ignored
    pulse_start(9'h040, 5'd8, 2);
    expect_run(9'h040, 5'd8, 2, 1'b1);

    // R10: start in the done cycle is accepted
    pulse_start(9'h120, 5'd3, 1);
    expect_run(9'h120, 5'd3, 1, 1'b0);
    chk(done_o == 1'b1, "R10 done visible before chained start", int'(done_o), 1);
    pulse_start(9'h0F5, 5'd11, 0);
    expect_run(9'h0F5, 5'd11, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule